// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two parallel ports, A and B, and moves a word from one to the other in either direction. Each direction owns a holding register. Every register loads on a low-to-high transition of its own capture strobe, and the two strobes are independent of each other. The system clock `clk_i` samples each strobe, and an edge detector turns a rising level into a single load. For each direction a select input chooses the value that goes out: either the live word on the opposite port, or the word held in that direction's register.

An active-low enable and a direction input decide which port is driven. At most one port is driven at a time, and neither is driven while the enable is high. Each port is split into an input, an output and an output-enable, so a pad ring or a tri-state wrapper can be placed around the block. Capture does not depend on enable or direction. While the outputs are isolated, both registers can still load, each from its own port. When a port is driven, its register stores the word the block is putting on that port.

Top module: `rbt_bus_xcvr`

## Requirements
- R1: While `en_n_i` is 1, `a_oe_o` and `b_oe_o` are both 0, and `a_o` and `b_o` both read all zeros.
- R2: While `en_n_i` is 0, `dir_i`=1 sets `b_oe_o`=1 and `a_oe_o`=0, and `dir_i`=0 sets `a_oe_o`=1 and `b_oe_o`=0. In either case the output of the port that is not driven reads all zeros.
- R3: While B is driven and `ab_sel_i`=0, `b_o` equals `a_i` in the same cycle.
- R4: While B is driven and `ab_sel_i`=1, `b_o` equals the A-to-B register.
- R5: While A is driven and `ba_sel_i`=0, `a_o` equals `b_i` in the same cycle.
- R6: While A is driven and `ba_sel_i`=1, `a_o` equals the B-to-A register.
- R7: At a `clk_i` edge where `ab_stb_i` is 1 and was 0 at the previous edge, the A-to-B register loads the A-side word, whatever the values of enable and direction. At every other edge it keeps its value.
- R8: At a `clk_i` edge where `ba_stb_i` is 1 and was 0 at the previous edge, the B-to-A register loads the B-side word, whatever the values of enable and direction. At every other edge it keeps its value.
- R9: The A-side word is `a_o` while A is driven and `a_i` otherwise. The B-side word is `b_o` while B is driven and `b_i` otherwise.
- R10: `rst_ni`=0 clears both registers to zero at once. After reset is released, a strobe that is already 1 does not cause a load until it has gone to 0 and back to 1.
- R11: `a_oe_o` and `b_oe_o` are never 1 together.
- R12: If a port shows stored data and its register loads at an edge, the port shows the old word up to that edge and the new word from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples both strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_n_i | input | 1 | Output enable, active low |
| dir_i | input | 1 | 1 drives B from A, 0 drives A from B |
| ab_sel_i | input | 1 | Source of B output: 0 live A, 1 stored |
| ba_sel_i | input | 1 | Source of A output: 0 live B, 1 stored |
| ab_stb_i | input | 1 | Capture strobe of the A-to-B register |
| ba_stb_i | input | 1 | Capture strobe of the B-to-A register |
| a_i | input | WIDTH | Word received at port A |
| a_o | output | WIDTH | Word driven onto port A |
| a_oe_o | output | 1 | Drive enable of port A |
| b_i | input | WIDTH | Word received at port B |
| b_o | output | WIDTH | Word driven onto port B |
| b_oe_o | output | 1 | Drive enable of port B |

## Verification
Two functions can fall in the same cycle: a port showing stored data, and a load of the register that feeds that port. The bench provokes this with directed strobes while the port is in stored mode. It expects the old word before the edge and the new word after it. The second overlap is a load taken from a driven port that is itself showing the other register. Random strobes across all sixteen combinations of enable, direction and the two selects produce both overlaps again, and a bench model that updates its registers only after each edge judges the result.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic [1:0] {
    PATH_OFF    = 2'd0,
    PATH_A_TO_B = 2'd1,
    PATH_B_TO_A = 2'd2
  } path_e;

  function automatic path_e pick_path(input logic en_n, input logic dir);
    if (en_n) return PATH_OFF;
    return dir ? PATH_A_TO_B : PATH_B_TO_A;
  endfunction
endpackage

// File: rtl/rbt_strobe_edge.sv
module rbt_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic rise_o
);
  logic prev_q;

  // reset high: a strobe held at release is not a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= stb_i;
  end

  assign rise_o = stb_i & ~prev_q;
endmodule

// File: rtl/rbt_hold_reg.sv
module rbt_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= 1'b0;
      else if (load_i) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/rbt_steer.sv
module rbt_steer
  import rbt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_n_i,
  input  logic             dir_i,
  input  logic             ab_sel_i,
  input  logic             ba_sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] ab_q_i,
  input  logic [WIDTH-1:0] ba_q_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  path_e path;

  always_comb begin
    path   = pick_path(en_n_i, dir_i);
    a_oe_o = (path == PATH_B_TO_A);
    b_oe_o = (path == PATH_A_TO_B);
    a_o    = '0;
    b_o    = '0;
    if (a_oe_o) a_o = ba_sel_i ? ba_q_i : b_i;
    if (b_oe_o) b_o = ab_sel_i ? ab_q_i : a_i;
  end
endmodule

// File: rtl/rbt_bus_xcvr.sv
module rbt_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_n_i,
  input  logic             dir_i,
  input  logic             ab_sel_i,
  input  logic             ba_sel_i,
  input  logic             ab_stb_i,
  input  logic             ba_stb_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  logic             ab_rise, ba_rise;
  logic [WIDTH-1:0] ab_q, ba_q;
  logic [WIDTH-1:0] a_side, b_side;

  // driven port captures what it drives
  assign a_side = a_oe_o ? a_o : a_i;
  assign b_side = b_oe_o ? b_o : b_i;

  rbt_strobe_edge u_ab_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .stb_i (ab_stb_i), .rise_o (ab_rise)
  );

  rbt_strobe_edge u_ba_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .stb_i (ba_stb_i), .rise_o (ba_rise)
  );

  rbt_hold_reg #(.WIDTH(WIDTH)) u_ab_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ab_rise), .d_i (a_side), .q_o (ab_q)
  );

  rbt_hold_reg #(.WIDTH(WIDTH)) u_ba_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ba_rise), .d_i (b_side), .q_o (ba_q)
  );

  rbt_steer #(.WIDTH(WIDTH)) u_steer (
    .en_n_i   (en_n_i),
    .dir_i    (dir_i),
    .ab_sel_i (ab_sel_i),
    .ba_sel_i (ba_sel_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .ab_q_i   (ab_q),
    .ba_q_i   (ba_q),
    .a_o      (a_o),
    .a_oe_o   (a_oe_o),
    .b_o      (b_o),
    .b_oe_o   (b_oe_o)
  );
endmodule

// File: rtl/rbt_bus_xcvr_chk.sv
module rbt_bus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_n_i,
  input logic             ab_sel_i,
  input logic             ba_sel_i,
  input logic             ab_stb_i,
  input logic             ba_stb_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o,
  input logic [WIDTH-1:0] ab_q,
  input logic [WIDTH-1:0] ba_q
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_n_i |-> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0)); // R1

  AST_B_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !ab_sel_i) |-> b_o == a_i); // R3

  AST_A_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && !ba_sel_i) |-> a_o == b_i); // R5

  AST_AB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$rose(ab_stb_i)) |=> $stable(ab_q)); // R7

  AST_AB_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $rose(ab_stb_i)) |=> ab_q == $past(a_oe_o ? a_o : a_i)); // R9

  AST_BA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$rose(ba_stb_i)) |=> $stable(ba_q)); // R8

  AST_BA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $rose(ba_stb_i)) |=> ba_q == $past(b_oe_o ? b_o : b_i)); // R9
endmodule

bind rbt_bus_xcvr rbt_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_n_i   (en_n_i),
  .ab_sel_i (ab_sel_i),
  .ba_sel_i (ba_sel_i),
  .ab_stb_i (ab_stb_i),
  .ba_stb_i (ba_stb_i),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o),
  .ab_q     (ab_q),
  .ba_q     (ba_q)
);

// File: tb/rbt_bus_xcvr_tb_top.sv
module rbt_bus_xcvr_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en_n = 1'b1, dir = 1'b0, sab = 1'b0, sba = 1'b0;
  logic         stab = 1'b0, stba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [W-1:0] ab_m, ba_m;
  logic         pab, pba;

  always #10 clk = ~clk;

  rbt_bus_xcvr #(.WIDTH(W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .en_n_i (en_n), .dir_i (dir),
    .ab_sel_i (sab), .ba_sel_i (sba), .ab_stb_i (stab), .ba_stb_i (stba),
    .a_i (a_in), .a_o (a_out), .a_oe_o (a_oe),
    .b_i (b_in), .b_o (b_out), .b_oe_o (b_oe)
  );

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_a(logic e, logic d, logic s);
    if (e) return "R1";
    if (d) return "R2";
    return s ? "R6" : "R5";
  endfunction

  function automatic string tag_b(logic e, logic d, logic s);
    if (e) return "R1";
    if (!d) return "R2";
    return s ? "R4" : "R3";
  endfunction

  // one cycle: drive at negedge, check before posedge, update model after it
  task automatic step(logic e, logic d, logic s_ab, logic s_ba, logic t_ab, logic t_ba,
                      logic [W-1:0] a, logic [W-1:0] b, string tag);
    logic         x_aoe, x_boe;
    logic [W-1:0] x_a, x_b, cap_a, cap_b;
    @(negedge clk);
    en_n = e; dir = d; sab = s_ab; sba = s_ba; stab = t_ab; stba = t_ba;
    a_in = a; b_in = b;
    #5;
    x_aoe = !e && !d;
    x_boe = !e && d;
    x_a = x_aoe ? (s_ba ? ba_m : b) : '0;
    x_b = x_boe ? (s_ab ? ab_m : a) : '0;
    cap_a = x_aoe ? x_a : a;  // R9
    cap_b = x_boe ? x_b : b;
    check(tag != "" ? tag : (e ? "R1" : "R2"), "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, x_aoe});
    check(tag != "" ? tag : (e ? "R1" : "R2"), "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, x_boe});
    check(tag != "" ? tag : tag_a(e, d, s_ba), "a_out", a_out, x_a);
    check(tag != "" ? tag : tag_b(e, d, s_ab), "b_out", b_out, x_b);
    if (a_oe && b_oe) check("R11", "both_oe", 1, 0);
    @(posedge clk);
    if (t_ab && !pab) ab_m = cap_a;  // R7
    if (t_ba && !pba) ba_m = cap_b;  // R8
    pab = t_ab;
    pba = t_ba;
  endtask

  task automatic do_reset(logic t_ab, logic t_ba);
    @(negedge clk);
    stab = t_ab; stba = t_ba;
    rst_n = 1'b0;
    #5;
    ab_m = '0; ba_m = '0; pab = 1'b1; pba = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    ab_m = '0; ba_m = '0; pab = 1'b1; pba = 1'b1;
    void'($urandom(32'h1d5e_0a47));
    repeat (3) @(posedge clk);
    do_reset(1'b0, 1'b0);

    // R10: registers read zero after reset
    step(0, 1, 1, 0, 0, 0, 8'h5a, 8'ha5, "R10");
    step(0, 0, 0, 1, 0, 0, 8'h5a, 8'ha5, "R10");

    // R1: isolation, both captures in the same cycle
    step(1, 0, 1, 1, 1, 1, 8'h3c, 8'hc3, "R1");
    step(1, 1, 1, 1, 0, 0, 8'h00, 8'h00, "R1");
    step(0, 1, 1, 0, 0, 0, 8'h11, 8'h22, "R4");  // R7 shows 3c
    step(0, 0, 0, 1, 0, 0, 8'h11, 8'h22, "R6");  // R8 shows c3

    // R12: load while showing stored data
    step(0, 1, 1, 0, 1, 0, 8'h99, 8'h00, "R12");
    step(0, 1, 1, 0, 1, 0, 8'h77, 8'h00, "R12");  // held high: no new load
    step(0, 1, 1, 0, 0, 0, 8'h77, 8'h00, "R12");

    // R9: A driven from stored B-to-A, A-to-B captures the driven word
    step(0, 0, 0, 1, 1, 0, 8'hee, 8'h44, "R9");
    step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R9");
    // R9: B driven live, B-to-A captures it
    step(0, 1, 0, 0, 0, 1, 8'h6d, 8'hf0, "R9");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R9");

    // R10: strobes high across reset release give no load
    do_reset(1'b1, 1'b1);
    step(0, 1, 1, 0, 1, 1, 8'hab, 8'hcd, "R10");
    step(0, 0, 0, 1, 1, 1, 8'hab, 8'hcd, "R10");
    step(0, 1, 1, 0, 0, 0, 8'hab, 8'hcd, "R10");

    // all control combinations
    for (int c = 0; c < 16; c++) begin
      step(c[3], c[2], c[1], c[0], 1, 1, W'($urandom), W'($urandom), "");
      step(c[3], c[2], c[1], c[0], 0, 0, W'($urandom), W'($urandom), "");
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[5] & r[4], r[3], r[2], r[1], r[0], 1'($urandom), W'($urandom), W'($urandom), "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule